// File: doc/BRIEF.md
# MMU Control and Exception Register Bank

This block sits beside a CPU core and holds the memory-mapped registers for address translation and exception status. These are an MMU control word, the page-table-entry high, low and assistance words, the translation-table base, the faulting address, the trap code, and the exception and interrupt event codes. Some writes have side effects. Setting the invalidate bit in the control word raises a one-clock invalidate pulse, and that bit is never stored. A write to the page-table-entry high word raises a one-clock flush pulse only when its address-space identifier (low 8 bits) changes. Three identification words are read-only and return parameter constants.

A second port serves a memory-mapped array window. Address bits 26:24 of a window access select one of eight regions. Accesses to the four translation-buffer regions go out on an external request port. Accesses to the four cache regions are accepted and dropped. The window only takes 32-bit accesses.

Top module: `mmu_ctl_bank`

## Requirements
- R1: After reset every writable register reads 0, and `inv_pulse`, `flush_pulse`, `reg_err` and `win_err` are low.
- R2: A write to offset 0x00 (MMU control) with bit 2 set raises `inv_pulse` for exactly the one cycle after the write. Bit 2 always reads back 0, and the other bits read back as written.
- R3: A write to offset 0x04 (page-table-entry high) raises `flush_pulse` for the one cycle after the write only if `reg_wdata[7:0]` differs from the stored bits 7:0. The full new value is stored either way.
- R4: The trap code (0x18), exception event (0x1C) and interrupt event (0x20) registers keep only bits 10:0 of a write. The upper bits read 0.
- R5: The assistance register (0x14) keeps only bits 3:0. Page-table-entry low (0x08), table base (0x0C) and fault address (0x10) keep all 32 bits.
- R6: Offsets 0x30, 0x40 and 0x44 return the parameters `CPU_VER`, `CACHE_VER` and `REV_ID`. Writes to these offsets are ignored and raise no error.
- R7: A read or write to any other offset returns 0 and raises `reg_err` for the one cycle after the access.
- R8: A 32-bit window access (`win_size` = 4, the access width in bytes) whose region field `win_addr[26:24]` is 2, 3, 6 or 7 raises `tlb_req` in the same cycle. That cycle also carries the region code on `tlb_region`, the address, the write flag and the write data.
- R9: A window access to region 0, 1, 4 or 5 raises no `tlb_req`. A read from one of these regions returns 0 with `win_rvalid` in the following cycle.
- R10: A window access with `win_size` other than 4 is not forwarded, returns 0, and raises `win_err` in the following cycle.
- R11: For a forwarded window read, `win_rdata` equals `tlb_rdata` and `win_rvalid` is high in the cycle after the request.
- R12: A register read returns its data on `reg_rdata` with `reg_rvalid` high in the cycle after the request. `reg_rvalid` is low in the cycle after that unless another read follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | Register write when high |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, one cycle after request |
| reg_rvalid | output | 1 | Read data valid |
| reg_err | output | 1 | Unmapped offset pulse |
| inv_pulse | output | 1 | Full translation invalidate pulse |
| flush_pulse | output | 1 | Address-space change flush pulse |
| win_req | input | 1 | Array window request |
| win_we | input | 1 | Window write when high |
| win_addr | input | WIN_AW | Window address, bits 26:24 pick the region |
| win_size | input | SIZE_W | Access width in bytes |
| win_wdata | input | DW | Window write data |
| win_rdata | output | DW | Window read data |
| win_rvalid | output | 1 | Window read data valid |
| win_err | output | 1 | Access-size error pulse |
| tlb_req | output | 1 | Forwarded translation-buffer access |
| tlb_we | output | 1 | Forwarded write flag |
| tlb_region | output | 3 | Forwarded region code |
| tlb_addr | output | WIN_AW | Forwarded address |
| tlb_wdata | output | DW | Forwarded write data |
| tlb_rdata | input | DW | External read data, valid the cycle after `tlb_req` |

## Verification
The hardest case to reach is the flush decision. Whether a write to the page-table-entry high word flushes depends on what was stored before it, not on the value written alone. The stimulus therefore first stores a known identifier. It then rewrites the word with different upper bits but the same low byte, and checks that no pulse appears and that the new upper bits are stored. Finally it changes only the low byte and checks that the pulse appears. The window tests place a wrong-size access on a translation region, so that size checking and region decode are both active in the same cycle.

// File: rtl/mmu_bank_pkg.sv
package mmu_bank_pkg;
   localparam int NUM_RW = 9;  // writable words, index i sits at byte offset 4*i

   localparam logic [7:0] OFF_MMUCTL   = 8'h00;
   localparam logic [7:0] OFF_PTEHI    = 8'h04;
   localparam logic [7:0] OFF_CPUVER   = 8'h30;
   localparam logic [7:0] OFF_CACHEVER = 8'h40;
   localparam logic [7:0] OFF_REVID    = 8'h44;

   typedef enum logic [2:0] {
      RG_IC_TAG   = 3'd0, RG_IC_LINE  = 3'd1,
      RG_IT_TAG   = 3'd2, RG_IT_ENTRY = 3'd3,
      RG_OC_TAG   = 3'd4, RG_OC_LINE  = 3'd5,
      RG_UT_TAG   = 3'd6, RG_UT_ENTRY = 3'd7
   } region_e;

   function automatic logic [7:0] rw_offset(int idx);
      return 8'(idx * 4);
   endfunction

   // number of low bits each writable word retains
   function automatic int keep_bits(int idx);
      case (idx)
         5:       return 4;
         6, 7, 8: return 11;
         default: return 32;
      endcase
   endfunction
endpackage

// File: rtl/mmu_reg_file.sv
module mmu_reg_file
   import mmu_bank_pkg::*;
#(
   parameter int DW = 32,
   parameter int AW = 8,
   parameter int INV_BIT = 2,
   parameter int ASID_W = 8,
   parameter logic [DW-1:0] CPU_VER = '0,
   parameter logic [DW-1:0] CACHE_VER = '0,
   parameter logic [DW-1:0] REV_ID = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          rvalid,
   output logic          err,
   output logic          inv_pulse,
   output logic          flush_pulse
);
   localparam int IDX_CTL = 0;
   localparam int IDX_PTEH = 1;

   logic [DW-1:0] store [NUM_RW];
   logic [NUM_RW-1:0] hit;
   logic const_hit;
   logic [DW-1:0] const_val, rd_mux;

   for (genvar g = 0; g < NUM_RW; g++) begin : g_word
      localparam int KEEP = (keep_bits(g) < DW) ? keep_bits(g) : DW;
      localparam logic [DW-1:0] LIVE = {DW{1'b1}} >> (DW - KEEP);
      localparam logic [DW-1:0] MASK =
         (g == IDX_CTL) ? (LIVE & ~(DW'(1) << INV_BIT)) : LIVE;
      logic [DW-1:0] q;
      assign hit[g] = (addr == AW'(rw_offset(g)));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else if (req && we && hit[g]) q <= wdata & MASK;
      end
      assign store[g] = q;
   end

   always_comb begin
      const_hit = 1'b1;
      if (addr == AW'(OFF_CPUVER))        const_val = CPU_VER;
      else if (addr == AW'(OFF_CACHEVER)) const_val = CACHE_VER;
      else if (addr == AW'(OFF_REVID))    const_val = REV_ID;
      else begin
         const_hit = 1'b0;
         const_val = '0;
      end
   end

   always_comb begin
      rd_mux = const_val;
      for (int i = 0; i < NUM_RW; i++)
         if (hit[i]) rd_mux = store[i];
   end

   logic asid_moved;
   assign asid_moved = (wdata[ASID_W-1:0] != store[IDX_PTEH][ASID_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         rvalid <= 1'b0;
         err <= 1'b0;
         inv_pulse <= 1'b0;
         flush_pulse <= 1'b0;
      end else begin
         rvalid <= req && !we;
         rdata <= (req && !we) ? rd_mux : '0;
         err <= req && !(|hit) && !const_hit;
         inv_pulse <= req && we && hit[IDX_CTL] && wdata[INV_BIT];
         flush_pulse <= req && we && hit[IDX_PTEH] && asid_moved;
      end
   end
endmodule

// File: rtl/mmu_win_decode.sv
module mmu_win_decode
   import mmu_bank_pkg::*;
#(
   parameter int DW = 32,
   parameter int WAW = 27,
   parameter int SIZE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_req,
   input  logic              win_we,
   input  logic [WAW-1:0]    win_addr,
   input  logic [SIZE_W-1:0] win_size,
   input  logic [DW-1:0]     win_wdata,
   output logic [DW-1:0]     win_rdata,
   output logic              win_rvalid,
   output logic              win_err,
   output logic              tlb_req,
   output logic              tlb_we,
   output logic [2:0]        tlb_region,
   output logic [WAW-1:0]    tlb_addr,
   output logic [DW-1:0]     tlb_wdata,
   input  logic [DW-1:0]     tlb_rdata
);
   localparam int REG_LSB = 24;
   localparam int WORD_BYTES = DW / 8;

   region_e region;
   logic size_ok, is_tlb, fwd, fwd_rd_q;

   assign region = region_e'(win_addr[REG_LSB+2:REG_LSB]);
   assign size_ok = (win_size == SIZE_W'(WORD_BYTES));
   // translation-buffer regions are 2,3,6,7: region bit 1 set
   assign is_tlb = (region == RG_IT_TAG) || (region == RG_IT_ENTRY) ||
                   (region == RG_UT_TAG) || (region == RG_UT_ENTRY);
   assign fwd = win_req && size_ok && is_tlb;

   assign tlb_req = fwd;
   assign tlb_we = win_we;
   assign tlb_region = region;
   assign tlb_addr = win_addr;
   assign tlb_wdata = win_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_rvalid <= 1'b0;
         win_err <= 1'b0;
         fwd_rd_q <= 1'b0;
      end else begin
         win_rvalid <= win_req && !win_we;
         win_err <= win_req && !size_ok;
         fwd_rd_q <= fwd && !win_we;
      end
   end

   assign win_rdata = fwd_rd_q ? tlb_rdata : '0;
endmodule

// File: rtl/mmu_ctl_bank.sv
module mmu_ctl_bank #(
   parameter int DW = 32,
   parameter int REG_AW = 8,
   parameter int WIN_AW = 27,
   parameter int SIZE_W = 3,
   parameter int INV_BIT = 2,
   parameter int ASID_W = 8,
   parameter logic [DW-1:0] CPU_VER = 32'h1357_0001,
   parameter logic [DW-1:0] CACHE_VER = 32'h2468_0002,
   parameter logic [DW-1:0] REV_ID = 32'h0000_00A3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_req,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   output logic              reg_rvalid,
   output logic              reg_err,
   output logic              inv_pulse,
   output logic              flush_pulse,
   input  logic              win_req,
   input  logic              win_we,
   input  logic [WIN_AW-1:0] win_addr,
   input  logic [SIZE_W-1:0] win_size,
   input  logic [DW-1:0]     win_wdata,
   output logic [DW-1:0]     win_rdata,
   output logic              win_rvalid,
   output logic              win_err,
   output logic              tlb_req,
   output logic              tlb_we,
   output logic [2:0]        tlb_region,
   output logic [WIN_AW-1:0] tlb_addr,
   output logic [DW-1:0]     tlb_wdata,
   input  logic [DW-1:0]     tlb_rdata
);
   if (DW != 32) begin : g_bad_dw
      $error("mmu_ctl_bank: DW must be 32");
   end
   if (REG_AW < 8) begin : g_bad_aw
      $error("mmu_ctl_bank: REG_AW must cover offset 0x44");
   end
   if (WIN_AW != 27) begin : g_bad_waw
      $error("mmu_ctl_bank: region field needs WIN_AW of 27");
   end
   if (SIZE_W < 3) begin : g_bad_sz
      $error("mmu_ctl_bank: SIZE_W must encode 4");
   end
   if (INV_BIT >= DW || ASID_W > DW || ASID_W < 1) begin : g_bad_fld
      $error("mmu_ctl_bank: field position out of range");
   end

   mmu_reg_file #(
      .DW(DW), .AW(REG_AW), .INV_BIT(INV_BIT), .ASID_W(ASID_W),
      .CPU_VER(CPU_VER), .CACHE_VER(CACHE_VER), .REV_ID(REV_ID)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .req(reg_req), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .rvalid(reg_rvalid), .err(reg_err),
      .inv_pulse(inv_pulse), .flush_pulse(flush_pulse)
   );

   mmu_win_decode #(.DW(DW), .WAW(WIN_AW), .SIZE_W(SIZE_W)) u_win (
      .clk(clk), .rst_n(rst_n),
      .win_req(win_req), .win_we(win_we), .win_addr(win_addr),
      .win_size(win_size), .win_wdata(win_wdata),
      .win_rdata(win_rdata), .win_rvalid(win_rvalid), .win_err(win_err),
      .tlb_req(tlb_req), .tlb_we(tlb_we), .tlb_region(tlb_region),
      .tlb_addr(tlb_addr), .tlb_wdata(tlb_wdata), .tlb_rdata(tlb_rdata)
   );
endmodule

// File: rtl/mmu_bank_chk.sv
module mmu_bank_chk
   import mmu_bank_pkg::*;
#(
   parameter int DW = 32,
   parameter int REG_AW = 8,
   parameter int SIZE_W = 3,
   parameter int INV_BIT = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_req,
   input logic              reg_we,
   input logic [REG_AW-1:0] reg_addr,
   input logic [DW-1:0]     reg_wdata,
   input logic              reg_rvalid,
   input logic              reg_err,
   input logic              inv_pulse,
   input logic              flush_pulse,
   input logic              win_req,
   input logic              win_we,
   input logic [SIZE_W-1:0] win_size,
   input logic [DW-1:0]     win_rdata,
   input logic              win_err,
   input logic              tlb_req,
   input logic [2:0]        tlb_region
);
   assert_inv_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && reg_we && reg_addr == REG_AW'(OFF_MMUCTL) && reg_wdata[INV_BIT]) |=> inv_pulse);

   assert_inv_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      inv_pulse |-> $past(reg_req && reg_we && reg_addr == REG_AW'(OFF_MMUCTL)));

   assert_flush_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flush_pulse |-> $past(reg_req && reg_we && reg_addr == REG_AW'(OFF_PTEHI)));

   assert_dec_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
      reg_err |-> $past(reg_req));

   assert_fwd_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_req |-> (win_req && win_size == SIZE_W'(4) && tlb_region[1]));

   assert_cache_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (win_req && !win_we && !tlb_req) |=> (win_rdata == '0));

   assert_size_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (win_req && win_size != SIZE_W'(4)) |=> win_err);

   assert_rvalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && !reg_we) |=> reg_rvalid);
endmodule

bind mmu_ctl_bank mmu_bank_chk #(
   .DW(DW), .REG_AW(REG_AW), .SIZE_W(SIZE_W), .INV_BIT(INV_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid),
   .reg_err(reg_err), .inv_pulse(inv_pulse), .flush_pulse(flush_pulse),
   .win_req(win_req), .win_we(win_we), .win_size(win_size),
   .win_rdata(win_rdata), .win_err(win_err), .tlb_req(tlb_req),
   .tlb_region(tlb_region)
);

// File: tb/sim_mmu_ctl_bank.sv
`timescale 1ns/1ps
module sim_mmu_ctl_bank;
   localparam logic [31:0] P_CPU = 32'h1357_0001;
   localparam logic [31:0] P_CACHE = 32'h2468_0002;
   localparam logic [31:0] P_REV = 32'h0000_00A3;
   localparam logic [31:0] EXT_DATA = 32'h5A5A_C3C3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_req = 1'b0, reg_we = 1'b0;
   logic [7:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic reg_rvalid, reg_err, inv_pulse, flush_pulse;
   logic win_req = 1'b0, win_we = 1'b0;
   logic [26:0] win_addr = '0;
   logic [2:0] win_size = '0;
   logic [31:0] win_wdata = '0;
   logic [31:0] win_rdata;
   logic win_rvalid, win_err, tlb_req, tlb_we;
   logic [2:0] tlb_region;
   logic [26:0] tlb_addr;
   logic [31:0] tlb_wdata;
   logic [31:0] tlb_rdata = EXT_DATA;

   always #2 clk = ~clk;

   mmu_ctl_bank #(.CPU_VER(P_CPU), .CACHE_VER(P_CACHE), .REV_ID(P_REV)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .reg_rvalid(reg_rvalid), .reg_err(reg_err), .inv_pulse(inv_pulse),
      .flush_pulse(flush_pulse), .win_req(win_req), .win_we(win_we),
      .win_addr(win_addr), .win_size(win_size), .win_wdata(win_wdata),
      .win_rdata(win_rdata), .win_rvalid(win_rvalid), .win_err(win_err),
      .tlb_req(tlb_req), .tlb_we(tlb_we), .tlb_region(tlb_region),
      .tlb_addr(tlb_addr), .tlb_wdata(tlb_wdata), .tlb_rdata(tlb_rdata)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // captured results of the last access
   logic [31:0] c_rd;
   logic c_err, c_rv, c_inv, c_fl;
   logic c_treq, c_twe;
   logic [2:0] c_treg;
   logic [26:0] c_taddr;
   logic [31:0] c_twd;

   task automatic reg_acc(input logic w, input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_req = 1'b1; reg_we = w; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      c_rd = reg_rdata; c_err = reg_err; c_rv = reg_rvalid;
      c_inv = inv_pulse; c_fl = flush_pulse;
      @(negedge clk);
      reg_req = 1'b0; reg_we = 1'b0;
   endtask

   task automatic win_acc(input logic w, input logic [26:0] a, input logic [2:0] sz,
                          input logic [31:0] d);
      @(negedge clk);
      win_req = 1'b1; win_we = w; win_addr = a; win_size = sz; win_wdata = d;
      #1;
      c_treq = tlb_req; c_twe = tlb_we; c_treg = tlb_region;
      c_taddr = tlb_addr; c_twd = tlb_wdata;
      @(posedge clk); #1;
      c_rd = win_rdata; c_rv = win_rvalid; c_err = win_err;
      @(negedge clk);
      win_req = 1'b0; win_we = 1'b0;
   endtask

   typedef struct packed {
      logic [3:0]  rq;
      logic [7:0]  off;
      logic [31:0] wd;
      logic [31:0] exp;
   } vec_t;

   // R2 control word, R3 page entry high, R5 full and masked words, R4 11-bit codes
   localparam vec_t VEC [9] = '{
      '{4'd2, 8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFB},
      '{4'd3, 8'h04, 32'h1234_5678, 32'h1234_5678},
      '{4'd5, 8'h08, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
      '{4'd5, 8'h0C, 32'h8000_0001, 32'h8000_0001},
      '{4'd5, 8'h10, 32'hCAFE_F00D, 32'hCAFE_F00D},
      '{4'd5, 8'h14, 32'hFFFF_FFFF, 32'h0000_000F},
      '{4'd4, 8'h18, 32'hFFFF_FFFF, 32'h0000_07FF},
      '{4'd4, 8'h1C, 32'hABCD_EF12, 32'h0000_0712},
      '{4'd4, 8'h20, 32'h0000_F800, 32'h0000_0000}
   };

   initial begin
      repeat (50000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 inv_pulse", 32'(inv_pulse), 32'd0);
      chk("R1 flush_pulse", 32'(flush_pulse), 32'd0);
      chk("R1 reg_err", 32'(reg_err), 32'd0);
      chk("R1 win_err", 32'(win_err), 32'd0);
      for (int i = 0; i < 9; i++) begin
         reg_acc(1'b0, 8'(i * 4), '0);
         chk("R1 reset readback", c_rd, 32'd0);
      end

      // table walk: write, read back
      for (int i = 0; i < 9; i++) begin
         reg_acc(1'b1, VEC[i].off, VEC[i].wd);
         reg_acc(1'b0, VEC[i].off, '0);
         checks++;
         if (c_rd !== VEC[i].exp) begin
            errors++;
            $display("FAIL R%0d offset %h actual=%h expected=%h",
                     VEC[i].rq, VEC[i].off, c_rd, VEC[i].exp);
         end
      end

      // R2 invalidate pulse and self-clearing bit
      reg_acc(1'b1, 8'h00, 32'h0000_0004);
      chk("R2 inv pulse", 32'(c_inv), 32'd1);
      @(posedge clk); #1;
      chk("R2 inv pulse ends", 32'(inv_pulse), 32'd0);
      reg_acc(1'b0, 8'h00, '0);
      chk("R2 bit clear", c_rd, 32'd0);
      reg_acc(1'b1, 8'h00, 32'h0000_0001);
      chk("R2 no inv", 32'(c_inv), 32'd0);

      // R3 flush decision depends on stored identifier (now 0x78)
      reg_acc(1'b1, 8'h04, 32'hAAAA_BB78);
      chk("R3 same asid no flush", 32'(c_fl), 32'd0);
      reg_acc(1'b0, 8'h04, '0);
      chk("R3 stored anyway", c_rd, 32'hAAAA_BB78);
      reg_acc(1'b1, 8'h04, 32'h0000_0079);
      chk("R3 asid change flush", 32'(c_fl), 32'd1);
      @(posedge clk); #1;
      chk("R3 flush ends", 32'(flush_pulse), 32'd0);
      reg_acc(1'b0, 8'h04, '0);
      chk("R3 new value", c_rd, 32'h0000_0079);

      // R6 identification constants
      reg_acc(1'b0, 8'h30, '0); chk("R6 cpu ver", c_rd, P_CPU);
      reg_acc(1'b0, 8'h40, '0); chk("R6 cache ver", c_rd, P_CACHE);
      reg_acc(1'b1, 8'h44, 32'hFFFF_FFFF); chk("R6 write no err", 32'(c_err), 32'd0);
      reg_acc(1'b0, 8'h44, '0); chk("R6 rev unchanged", c_rd, P_REV);

      // R7 unmapped offsets
      reg_acc(1'b0, 8'h24, '0);
      chk("R7 read zero", c_rd, 32'd0);
      chk("R7 err", 32'(c_err), 32'd1);
      reg_acc(1'b1, 8'h50, 32'h1);
      chk("R7 write err", 32'(c_err), 32'd1);

      // R12 read timing
      reg_acc(1'b0, 8'h08, '0);
      chk("R12 rvalid", 32'(c_rv), 32'd1);
      @(posedge clk); #1;
      chk("R12 rvalid drops", 32'(reg_rvalid), 32'd0);

      // R8 forwarded write to region 6
      win_acc(1'b1, 27'h600_0120, 3'd4, 32'h0BAD_F00D);
      chk("R8 tlb_req", 32'(c_treq), 32'd1);
      chk("R8 region", 32'(c_treg), 32'd6);
      chk("R8 addr", 32'(c_taddr), 32'h0600_0120);
      chk("R8 we", 32'(c_twe), 32'd1);
      chk("R8 data", c_twd, 32'h0BAD_F00D);

      // R11 forwarded read from region 3
      win_acc(1'b0, 27'h300_0040, 3'd4, '0);
      chk("R11 tlb_req", 32'(c_treq), 32'd1);
      chk("R11 region", 32'(c_treg), 32'd3);
      chk("R11 rdata", c_rd, EXT_DATA);
      chk("R11 rvalid", 32'(c_rv), 32'd1);

      // R9 cache region read
      win_acc(1'b0, 27'h400_0008, 3'd4, '0);
      chk("R9 no forward", 32'(c_treq), 32'd0);
      chk("R9 rdata zero", c_rd, 32'd0);
      chk("R9 rvalid", 32'(c_rv), 32'd1);

      // R10 wrong size on a translation region
      win_acc(1'b0, 27'h700_0010, 3'd2, '0);
      chk("R10 no forward", 32'(c_treq), 32'd0);
      chk("R10 err", 32'(c_err), 32'd1);
      chk("R10 rdata zero", c_rd, 32'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule